// File: doc/BRIEF.md
# Write-Status Polling Read Path

This block sits in the read path of a byte-wide nonvolatile memory. While an internal programming cycle is running, it replaces the array's read data with a status pattern, so that a host can find out when the write has finished without a separate interrupt line.

The block offers two ways to poll. In the first, the host compares bit 7 of a read against the byte it wrote last; that bit comes back inverted until programming ends. In the second, the host reads twice and looks at bit 6, which alternates on every new read access while the part is busy and holds still once it is idle.

A read access needs both enables low with the write strobe high. The start of a new access is the point where that combined enable turns on, whether the host reaches it by pulsing the output enable, the chip enable, or both. The block keeps a copy of the most recently loaded byte and samples the busy flag in the same clock as the read, so the first read after programming completes returns true array data. The programming timer is outside this block. A protected-mode write that stores nothing still raises the busy flag, and reads during that cycle report status in the same way.

Top module: `wstat_read_path`

## Requirements
- R1: While reset is asserted, and on the first edge after its release, `bus_drive` is 0, `bus_dout` is 0, and the internal toggle state is 0.
- R2: `bus_drive` is 1 in the cycle after an edge at which `ce_n`=0, `oe_n`=0 and `we_n`=1 are all sampled. Otherwise it is 0, and `bus_dout` is then 0x00.
- R3: During a read sampled with `busy`=0, `bus_dout` equals the `arr_rdata` sampled at that edge.
- R4: During a read sampled with `busy`=1, bit 7 of `bus_dout` is the complement of bit 7 of the last loaded byte.
- R5: The toggle state flips at every edge where a new read starts (read enable sampled 1 after being sampled 0) while `busy`=1. Bit 6 of `bus_dout` during a busy read shows the flipped value, so the first busy read after reset returns 1 in bit 6.
- R6: The toggle state does not change during a read that is held across several edges, and it does not change while `busy`=0. The value it keeps is used by the next busy read.
- R7: During a read sampled with `busy`=1, bits 5..0 of `bus_dout` equal bits 5..0 of the last loaded byte, whatever `arr_rdata` holds.
- R8: At an edge where `wr_load`=1, `wr_data` becomes the last loaded byte, and it is seen from the next edge on. Without `wr_load` the stored byte is kept.
- R9: `busy` is sampled at the same edge as the read. A read sampled with `busy`=0 right after a busy read returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low; a low value blocks a read |
| busy | input | 1 | Internal programming cycle in progress |
| arr_rdata | input | DATA_W | Data read from the array |
| wr_load | input | 1 | Captures `wr_data` as the last loaded byte |
| wr_data | input | DATA_W | Byte being loaded by the host |
| bus_dout | output | DATA_W | Value driven onto the data bus |
| bus_drive | output | 1 | Bus drive enable |

## Verification
Reads are started in three ways: by pulsing the output enable with the chip enable held low, by pulsing the chip enable with the output enable held low, and by holding one read across several cycles. This shows that a fresh access flips bit 6 and a held access does not. The last loaded byte is given both values of bit 7, and the array data changes during busy reads. These cases separate an inverted bit 7 from a copied bit, and show that the low bits come from the stored byte rather than from the array. Dropping `busy` between two reads, and raising it again later, checks that array data returns at once and that the toggle picks up from the value it kept.

// File: rtl/wstat_pkg.sv
package wstat_pkg;

  // Assemble the busy-time status byte from the stored byte and toggle state.
  function automatic logic [7:0] status_byte8(input logic [7:0] last_b, input logic tgl);
    status_byte8 = {~last_b[7], tgl, last_b[5:0]};
  endfunction

  typedef enum logic [1:0] {
    RD_IDLE  = 2'b00,
    RD_START = 2'b01,
    RD_HOLD  = 2'b11
  } rd_phase_e;

endpackage

// File: rtl/wstat_rst_sync.sv
module wstat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wstat_strobe.sv
module wstat_strobe
  import wstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      we_n,
  output logic      rd_en,
  output logic      rd_start,
  output rd_phase_e rd_phase
);
  logic rd_prev_q;
  logic rd_prev_d;

  always_comb begin
    rd_en     = ~ce_n & ~oe_n & we_n;
    rd_start  = rd_en & ~rd_prev_q;
    rd_prev_d = rd_en;
    if (!rd_en)        rd_phase = RD_IDLE;
    else if (rd_start) rd_phase = RD_START;
    else               rd_phase = RD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev_q <= 1'b0;
    else        rd_prev_q <= rd_prev_d;
  end
endmodule

// File: rtl/wstat_last_byte.sv
module wstat_last_byte #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] last_q
);
  logic [DATA_W-1:0] last_d;

  always_comb begin
    last_d = last_q;
    if (load_en) last_d = load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle
  import wstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  rd_phase_e rd_phase,
  output logic      tgl_next,
  output logic      tgl_q
);
  logic tgl_en;

  always_comb begin
    tgl_en   = busy & (rd_phase == RD_START);
    tgl_next = tgl_en ? ~tgl_q : tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tgl_q <= 1'b0;
    else if (tgl_en) tgl_q <= tgl_next;
  end
endmodule

// File: rtl/wstat_outmux.sv
module wstat_outmux #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              tgl_next,
  input  logic [DATA_W-1:0] last_b,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout_q,
  output logic              drive_q
);
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] dout_d;

  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (b == POLL_BIT) begin : g_poll
      assign status_w[b] = ~last_b[b];
    end else if (b == TGL_BIT) begin : g_tgl
      assign status_w[b] = tgl_next;
    end else begin : g_copy
      assign status_w[b] = last_b[b];
    end
  end

  always_comb begin
    dout_d = '0;
    if (rd_en) dout_d = busy ? status_w : arr_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      drive_q <= 1'b0;
    end else begin
      dout_q  <= dout_d;
      drive_q <= rd_en;
    end
  end
endmodule

// File: rtl/wstat_read_path.sv
module wstat_read_path
  import wstat_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6,
  parameter int unsigned RST_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              busy,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_drive
);
  logic              rst_i_n;
  logic              rd_en;
  logic              rd_start;
  rd_phase_e         rd_phase;
  logic              tgl_next;
  logic              tgl_q;
  logic [DATA_W-1:0] last_q;

  wstat_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  wstat_strobe u_strb (
    .clk(clk), .rst_n(rst_i_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .rd_en(rd_en), .rd_start(rd_start), .rd_phase(rd_phase)
  );

  wstat_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk(clk), .rst_n(rst_i_n), .load_en(wr_load), .load_data(wr_data),
    .last_q(last_q)
  );

  wstat_toggle u_tgl (
    .clk(clk), .rst_n(rst_i_n), .busy(busy), .rd_phase(rd_phase),
    .tgl_next(tgl_next), .tgl_q(tgl_q)
  );

  wstat_outmux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) u_mux (
    .clk(clk), .rst_n(rst_i_n), .rd_en(rd_en), .busy(busy),
    .tgl_next(tgl_next), .last_b(last_q), .arr_rdata(arr_rdata),
    .dout_q(bus_dout), .drive_q(bus_drive)
  );
endmodule

// File: rtl/wstat_read_path_chk.sv
module wstat_read_path_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input logic              clk,
  input logic              rst_i_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              busy,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] last_q,
  input logic              rd_start,
  input logic              tgl_q,
  input logic [DATA_W-1:0] bus_dout,
  input logic              bus_drive
);
  logic rd_w;
  assign rd_w = ~ce_n & ~oe_n & we_n;

  // R2
  drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_w |=> bus_drive);

  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_w |=> (!bus_drive && bus_dout == '0));

  // R3
  array_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_w && !busy) |=> bus_dout == $past(arr_rdata));

  // R4
  poll_bit_inv_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_w && busy) |=> bus_dout[POLL_BIT] == ~$past(last_q[POLL_BIT]));

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_start && busy) |=> tgl_q != $past(tgl_q));

  // R6
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(rd_start && busy) |=> $stable(tgl_q));

  // R6
  toggle_shown_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_w && busy) |=> bus_dout[TGL_BIT] == tgl_q);
endmodule

bind wstat_read_path wstat_read_path_chk #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)
) u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .busy(busy), .arr_rdata(arr_rdata), .last_q(last_q), .rd_start(rd_start),
  .tgl_q(tgl_q), .bus_dout(bus_dout), .bus_drive(bus_drive)
);

// File: tb/test_wstat_read_path.sv
module test_wstat_read_path;
  logic       clk;
  logic       rst_n;
  logic       ce_n, oe_n, we_n, busy, wr_load;
  logic [7:0] arr_rdata, wr_data;
  logic [7:0] bus_dout;
  logic       bus_drive;

  int checks;
  int errors;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  // Bench reference state
  logic       m_tgl;
  logic [7:0] m_last;
  logic       m_prev;

  wstat_read_path i_wstat_read_path (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .busy(busy), .arr_rdata(arr_rdata), .wr_load(wr_load), .wr_data(wr_data),
    .bus_dout(bus_dout), .bus_drive(bus_drive)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({bus_drive, bus_dout} !== e) begin
        errors++;
        $display("FAIL %s: got drive=%0b dout=%02h, expected drive=%0b dout=%02h",
                 t, bus_drive, bus_dout, e[8], e[7:0]);
      end
    end
  end

  task automatic step(input logic c, input logic o, input logic w, input logic b,
                      input logic [7:0] arr, input logic ld, input logic [7:0] wd,
                      input string tag);
    logic       rd;
    logic [7:0] ed;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; busy = b; arr_rdata = arr;
    wr_load = ld; wr_data = wd;
    rd = !c && !o && w;
    if (rd && !m_prev && b) m_tgl = ~m_tgl;
    ed = 8'h00;
    if (rd) ed = b ? {~m_last[7], m_tgl, m_last[5:0]} : arr;
    exp_q.push_back({rd, ed});
    tag_q.push_back(tag);
    if (ld) m_last = wd;
    m_prev = rd;
  endtask

  task automatic idle(input logic b, input string tag);
    step(1'b1, 1'b1, 1'b1, b, 8'hEE, 1'b0, 8'h00, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end, expected end of test");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    m_tgl = 1'b0; m_last = 8'h00; m_prev = 1'b0;
    rst_n = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; busy = 1'b0;
    arr_rdata = 8'h00; wr_load = 1'b0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (bus_drive !== 1'b0 || bus_dout !== 8'h00) begin
      errors++;
      $display("FAIL R1: got drive=%0b dout=%02h, expected drive=0 dout=00", bus_drive, bus_dout);
    end
    rst_n = 1'b1;
    repeat (3) idle(1'b0, "R1");

    // R2/R3: plain reads while idle, two data patterns
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h5A, 1'b0, 8'h00, "R3");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 1'b0, 8'h00, "R3");
    // R2: WE low blocks the read
    step(1'b0, 1'b0, 1'b0, 1'b0, 8'h77, 1'b0, 8'h00, "R2");
    step(1'b0, 1'b1, 1'b1, 1'b0, 8'h77, 1'b0, 8'h00, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 1'b0, 8'h00, "R2");

    // R8: load a byte with bit 7 clear
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h3C, "R8");
    idle(1'b1, "R2");

    // R4/R5/R7: busy reads started by OE pulses, array data changes
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h00, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, "R2");
    // R5: read started by CE pulse
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h12, 1'b0, 8'h00, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h12, 1'b0, 8'h00, "R5");
    // R6: held read, no toggle
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h34, 1'b0, 8'h00, "R6");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h56, 1'b0, 8'h00, "R7");
    // R9: busy drops while read held: array data at once
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h9C, 1'b0, 8'h00, "R9");
    idle(1'b0, "R2");
    // R6: idle reads keep toggle state
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h61, 1'b0, 8'h00, "R6");
    idle(1'b0, "R2");

    // R8: new byte with bit 7 set, protected-style busy cycle
    step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'hC5, "R8");
    idle(1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'hAA, 1'b0, 8'h00, "R4");
    idle(1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 8'h00, "R7");
    // R8: load without strobe is ignored
    step(1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h0F, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, "R8");
    idle(1'b0, "R2");
    step(1'b0, 1'b0, 1'b1, 1'b0, 8'h3E, 1'b0, 8'h00, "R9");
    idle(1'b0, "R2");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule